// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block drives one system reset from two causes: a digital flag from an external comparator that reports the supply is below its trip point, and a watchdog that expects the host to pulse a shared select line. Whenever either cause fires, the reset goes active. It is released only after the supply has been good without a break for a programmable hold interval. Power-up, through the synchronous `rst` input, counts as such a cause, so reset is active from the first clock. The same hold interval follows a watchdog expiry.

The watchdog restarts on a falling edge of the select/kick line, after a two-flop synchronizer. A line held steady high or steady low therefore still times out. A two-bit field picks one of three timeout lengths or turns the watchdog off. Changing the field restarts the count. All interval lengths are parameters, so a short simulation can use small counts.

Top module: `supv_reset_wdog`

## Requirements
- R1: Once `supply_low_i` is sampled high at a clock edge, `sys_reset_o` is 1 after that edge and stays 1 while the flag remains high.
- R2: `sys_reset_o` falls after the HOLD_CYC-th consecutive edge at which `supply_low_i` is sampled low and no other cause is present.
- R3: If `supply_low_i` is sampled high during the hold interval, the good-supply count starts again from zero.
- R4: While `rst` is high, `sys_reset_o` is 1 from the first edge. After `rst` falls it is released at the HOLD_CYC-th following edge.
- R5: `kick_i` passes through two synchronizer flops. A 1-to-0 change on it clears the watchdog count at the third clock edge after the change is first sampled. Kicks more frequent than the timeout keep reset from firing.
- R6: With the watchdog enabled and `kick_i` held at either level, reset is asserted at the L-th edge after the watchdog starts counting. L is the selected limit. `wdog_expired_o` is 1 for the whole hold that follows.
- R7: Select encoding of `period_sel_i`: 2'b00 gives LONG_CYC, 2'b01 gives MID_CYC, 2'b10 gives SHORT_CYC, and 2'b11 disables the watchdog. With 2'b11 no timeout occurs.
- R8: Any edge at which `period_sel_i` differs from its value at the previous edge clears the watchdog count.
- R9: The watchdog count is held at zero while reset is active. It starts from zero at the first edge after release.
- R10: `wdog_expired_o` is 0 whenever the active hold was caused by the supply flag or by `rst`. A supply drop overrides a watchdog cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| supply_low_i | input | 1 | Comparator flag, 1 = supply below trip |
| kick_i | input | 1 | Shared select line; a falling edge kicks the watchdog |
| period_sel_i | input | 2 | Timeout select (00 long, 01 mid, 10 short, 11 off) |
| sys_reset_o | output | 1 | System reset, active high |
| wdog_expired_o | output | 1 | 1 while the current hold was started by a watchdog expiry |

## Verification
The supply flag affects `sys_reset_o` one edge after it is sampled. A kick reaches the watchdog count three edges after its change, because of the two synchronizer flops plus the edge-detect flop. A timeout raises reset at the same edge where the count reaches its limit. The bench keeps a behavioural model that advances at every rising edge on the same sampled inputs. It compares both outputs at every falling edge, where all those latencies have already settled. Directed checks at hand-counted offsets confirm the power-up release edge and the first timeout edge.

// File: rtl/supv_pkg.sv
package supv_pkg;

    // Watchdog period select encoding; the 2'b11 code turns the watchdog off.
    typedef enum logic [1:0] {
        PSEL_LONG  = 2'b00,
        PSEL_MID   = 2'b01,
        PSEL_SHORT = 2'b10,
        PSEL_OFF   = 2'b11
    } period_sel_e;

    // Reason the reset hold is currently active.
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_SUPPLY = 2'b01,
        CAUSE_WDOG   = 2'b10,
        CAUSE_POR    = 2'b11
    } hold_cause_e;

    // Events passed from the watchdog to the hold timer.
    typedef struct packed {
        logic trip;
        logic rewind;
    } wd_event_t;

    // Bits needed for a counter that runs from 0 to n-1.
    function automatic int unsigned cnt_bits(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Timeout length for a select code; 0 means disabled.
    function automatic int unsigned pick_limit(period_sel_e s, int unsigned lng,
                                               int unsigned mid, int unsigned sht);
        case (s)
            PSEL_LONG:  return lng;
            PSEL_MID:   return mid;
            PSEL_SHORT: return sht;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/supv_kick_sync.sv
module supv_kick_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_i,
    output logic fall_o
);
    // sh[0..STAGES-1] form the synchronizer, sh[STAGES] holds the prior value.
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], kick_i};
        end
    end

    assign fall_o = sh[STAGES] & ~sh[STAGES-1];

    // R5: an edge pulse lasts exactly one cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/supv_watchdog.sv
module supv_watchdog
    import supv_pkg::*;
#(
    parameter int unsigned LONG_CYC  = 140_000_000,
    parameter int unsigned MID_CYC   = 60_000_000,
    parameter int unsigned SHORT_CYC = 15_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hold_i,
    input  logic [1:0]  sel_i,
    input  logic        kick_fall_i,
    output wd_event_t   evt_o
);
    localparam int unsigned MAX_CYC = max3(LONG_CYC, MID_CYC, SHORT_CYC);
    localparam int unsigned CW      = cnt_bits(MAX_CYC);

    period_sel_e   sel_e;
    period_sel_e   sel_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_cnt;
    int unsigned   lim;

    assign sel_e    = period_sel_e'(sel_i);
    assign lim      = pick_limit(sel_e, LONG_CYC, MID_CYC, SHORT_CYC);
    assign last_cnt = CW'(lim - 1);

    always_comb begin
        evt_o.rewind = hold_i | (sel_e == PSEL_OFF) | kick_fall_i | (sel_e != sel_q);
        evt_o.trip   = !evt_o.rewind && (cnt_q == last_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sel_q <= PSEL_OFF;
        end else begin
            sel_q <= sel_e;
            if (evt_o.rewind || evt_o.trip) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // R9: count parked while reset holds
    a_r9_idle_in_hold: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> (cnt_q == '0));
    // R8: select change rewinds
    a_r8_sel_change_rewinds: assert property (@(posedge clk) disable iff (rst)
        (sel_e != sel_q) |=> (cnt_q == '0));
    // R7: disabled code keeps the count at zero
    a_r7_off_idle: assert property (@(posedge clk) disable iff (rst)
        (sel_e == PSEL_OFF) |=> (cnt_q == '0));
    // R5: kick rewinds
    a_r5_kick_rewinds: assert property (@(posedge clk) disable iff (rst)
        kick_fall_i |=> (cnt_q == '0));

endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer
    import supv_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 20_000_000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      supply_low_i,
    input  wd_event_t evt_i,
    output logic      hold_o,
    output logic      wd_cause_o
);
    localparam int unsigned   CW   = cnt_bits(HOLD_CYC);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    typedef struct packed {
        logic          active;
        hold_cause_e   cause;
        logic [CW-1:0] cnt;
    } hold_state_t;

    hold_state_t cur, nxt;

    always_comb begin
        nxt = cur;
        if (supply_low_i) begin
            nxt.active = 1'b1;
            nxt.cause  = CAUSE_SUPPLY;
            nxt.cnt    = '0;
        end else if (evt_i.trip) begin
            nxt.active = 1'b1;
            nxt.cause  = CAUSE_WDOG;
            nxt.cnt    = '0;
        end else if (cur.active) begin
            if (cur.cnt == LAST) begin
                nxt.active = 1'b0;
                nxt.cause  = CAUSE_NONE;
                nxt.cnt    = '0;
            end else begin
                nxt.cnt = cur.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.active <= 1'b1;
            cur.cause  <= CAUSE_POR;
            cur.cnt    <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign hold_o     = cur.active;
    assign wd_cause_o = cur.active && (cur.cause == CAUSE_WDOG);

    // R1: low supply forces reset
    a_r1_low_holds: assert property (@(posedge clk) disable iff (rst)
        supply_low_i |=> hold_o);
    // R3: low supply rewinds the hold count
    a_r3_low_rewinds: assert property (@(posedge clk) disable iff (rst)
        supply_low_i |=> (cur.cnt == '0));
    // R2: release only after a good-supply edge
    a_r2_release_after_good: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_o) |-> $past(!supply_low_i));
    // R10: supply cause never flagged as watchdog expiry
    a_r10_supply_not_wdog: assert property (@(posedge clk) disable iff (rst)
        supply_low_i |=> !wd_cause_o);

endmodule

// File: rtl/supv_reset_wdog.sv
module supv_reset_wdog
    import supv_pkg::*;
#(
    parameter int unsigned HOLD_CYC  = 20_000_000,
    parameter int unsigned LONG_CYC  = 140_000_000,
    parameter int unsigned MID_CYC   = 60_000_000,
    parameter int unsigned SHORT_CYC = 15_000_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_low_i,
    input  logic       kick_i,
    input  logic [1:0] period_sel_i,
    output logic       sys_reset_o,
    output logic       wdog_expired_o
);
    logic      kick_fall;
    logic      hold;
    wd_event_t wd_evt;

    supv_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .kick_i (kick_i),
        .fall_o (kick_fall)
    );

    supv_watchdog #(
        .LONG_CYC  (LONG_CYC),
        .MID_CYC   (MID_CYC),
        .SHORT_CYC (SHORT_CYC)
    ) u_wdog (
        .clk         (clk),
        .rst         (rst),
        .hold_i      (hold),
        .sel_i       (period_sel_i),
        .kick_fall_i (kick_fall),
        .evt_o       (wd_evt)
    );

    supv_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk          (clk),
        .rst          (rst),
        .supply_low_i (supply_low_i),
        .evt_i        (wd_evt),
        .hold_o       (hold),
        .wd_cause_o   (wdog_expired_o)
    );

    assign sys_reset_o = hold;

    // R6: a timeout enters a watchdog-flagged reset
    a_r6_trip_resets: assert property (@(posedge clk) disable iff (rst)
        (wd_evt.trip && !supply_low_i) |=> (sys_reset_o && wdog_expired_o));

endmodule

// File: tb/supv_reset_wdog_tb_top.sv
module supv_reset_wdog_tb_top;

    localparam int HOLD  = 20;
    localparam int LONGC = 100;
    localparam int MIDC  = 60;
    localparam int SHRT  = 30;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_low = 1'b0;
    logic       kick = 1'b1;
    logic [1:0] sel = 2'b10;
    logic       sys_reset;
    logic       wd_exp;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R4";
    bit    started = 1'b0;

    // reference model state
    bit m_hold;
    int m_cause;      // 0 none, 1 supply, 2 watchdog, 3 power-up
    int m_cnt;
    int w_cnt;
    int sel_prev;
    bit k1, k2, k3;

    always #5 clk = ~clk;

    supv_reset_wdog #(
        .HOLD_CYC  (HOLD),
        .LONG_CYC  (LONGC),
        .MID_CYC   (MIDC),
        .SHORT_CYC (SHRT)
    ) dut_i (
        .clk            (clk),
        .rst            (rst),
        .supply_low_i   (supply_low),
        .kick_i         (kick),
        .period_sel_i   (sel),
        .sys_reset_o    (sys_reset),
        .wdog_expired_o (wd_exp)
    );

    always @(posedge clk) begin
        int  lim;
        bit  fall, restart, trip;
        if (rst) begin
            m_hold = 1; m_cause = 3; m_cnt = 0;
            w_cnt = 0; sel_prev = 3; k1 = 0; k2 = 0; k3 = 0;
        end else begin
            fall = k3 && !k2;
            case (sel)
                2'b00:   lim = LONGC;
                2'b01:   lim = MIDC;
                2'b10:   lim = SHRT;
                default: lim = 0;
            endcase
            restart = m_hold || (sel == 2'b11) || fall || (int'(sel) != sel_prev);
            trip = !restart && (w_cnt == lim - 1);
            w_cnt = (restart || trip) ? 0 : w_cnt + 1;
            sel_prev = int'(sel);
            k3 = k2; k2 = k1; k1 = kick;
            if (supply_low) begin
                m_hold = 1; m_cause = 1; m_cnt = 0;
            end else if (trip) begin
                m_hold = 1; m_cause = 2; m_cnt = 0;
            end else if (m_hold) begin
                if (m_cnt == HOLD - 1) begin
                    m_hold = 0; m_cause = 0; m_cnt = 0;
                end else begin
                    m_cnt++;
                end
            end
        end
        started = 1'b1;
    end

    task automatic chk(string req, string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual=%b expected=%b", req, what, $time, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            chk(tag, "sys_reset_o", sys_reset, m_hold);
            chk(tag, "wdog_expired_o", wd_exp, m_hold && (m_cause == 2));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R4: power-up hold, watchdog short, kick steady high
        cyc(3);
        chk("R4", "reset during rst", sys_reset, 1'b1);
        rst = 1'b0;
        cyc(HOLD - 1);
        chk("R4", "still held before release", sys_reset, 1'b1);
        cyc(1);
        chk("R2", "released after hold", sys_reset, 1'b0);
        // R6: steady-high kick times out at the SHRT-th edge
        tag = "R6";
        cyc(SHRT - 1);
        chk("R6", "no timeout yet", sys_reset, 1'b0);
        cyc(1);
        chk("R6", "timeout reset", sys_reset, 1'b1);
        chk("R6", "timeout flag", wd_exp, 1'b1);
        // R6 with line held low; R9 restart after hold
        kick = 1'b0;
        tag = "R9";
        cyc(2 * (HOLD + SHRT) + 4);
        // R5: frequent kicks keep reset released
        tag = "R5";
        cyc(HOLD + 2);
        for (int i = 0; i < 20; i++) begin
            kick = ~kick;
            cyc(8);
        end
        chk("R5", "kicked watchdog quiet", sys_reset, 1'b0);
        // R7: middle then long period with steady line
        tag = "R7";
        sel = 2'b01;
        cyc(MIDC + HOLD + 10);
        sel = 2'b00;
        cyc(LONGC + HOLD + 10);
        sel = 2'b11;
        cyc(HOLD + 5);
        cyc(3 * LONGC);
        chk("R7", "disabled never trips", sys_reset, 1'b0);
        // R8: alternating select restarts count
        tag = "R8";
        for (int i = 0; i < 15; i++) begin
            sel = (i % 2 == 0) ? 2'b00 : 2'b01;
            cyc(20);
        end
        chk("R8", "select changes rewind", sys_reset, 1'b0);
        // R1, R3, R10: supply drops, including one inside the hold
        tag = "R1";
        supply_low = 1'b1;
        cyc(1);
        chk("R1", "reset on low supply", sys_reset, 1'b1);
        chk("R10", "supply not watchdog", wd_exp, 1'b0);
        cyc(5);
        supply_low = 1'b0;
        tag = "R3";
        cyc(HOLD / 2);
        supply_low = 1'b1;
        cyc(2);
        supply_low = 1'b0;
        cyc(HOLD - 1);
        chk("R3", "hold restarted", sys_reset, 1'b1);
        cyc(1);
        chk("R3", "release after full hold", sys_reset, 1'b0);
        // R10: supply drop during a watchdog hold overrides the cause
        tag = "R10";
        sel = 2'b10;
        cyc(SHRT + 3);
        supply_low = 1'b1;
        cyc(1);
        chk("R10", "supply overrides watchdog", wd_exp, 1'b0);
        supply_low = 1'b0;
        cyc(HOLD + 5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL run timeout: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule